// File: doc/BRIEF.md
# Double-Precision Duplicate-Move Unit

This block executes one SIMD move that copies double-precision elements into a vector register file it owns. It takes an instruction that has already been decoded. The instruction carries an encoding kind, 3-bit destination and source register numbers, one extension bit for each of those numbers, a flag for 64-bit mode, a register-or-memory select, the 4-bit VEX.vvvv field and the load data. From these the unit builds a vector in which elements are duplicated. It then writes that vector into the destination register, following the rule that the encoding sets for the bits above the low 128.

The operation always copies the lowest 64-bit element into both halves of the low 128 bits. What happens to the bits above depends on the encoding. The legacy encoding keeps them. The VEX 128-bit encoding clears them. The VEX 256-bit encoding fills them by copying the third element into both halves of the second 128-bit lane. A VEX encoding whose vvvv field is not all ones is rejected with an undefined-opcode flag and writes nothing. The reserved encoding is rejected the same way. A combinational read port exposes any register, so the surrounding pipeline and the bench can observe the register file.

Top module: `dupmov_unit`

## Requirements
- R1: After an accepted operation, destination bits [63:0] and [127:64] both equal source bits [63:0]. The register form reads the whole source register.
- R2: The legacy encoding (in_enc = 2'b00) leaves destination bits [255:128] at their previous value.
- R3: The VEX 128-bit encoding (in_enc = 2'b01) clears destination bits [255:128] to zero.
- R4: The VEX 256-bit encoding (in_enc = 2'b10) writes source bits [191:128] into both destination bits [191:128] and [255:192].
- R5: The memory form (in_use_mem = 1) of the legacy and VEX 128-bit encodings uses only in_mem_data[63:0], and bits [255:64] have no effect. The VEX 256-bit memory form uses all 256 bits of in_mem_data.
- R6: A VEX encoding (2'b01 or 2'b10) with in_vvvv other than 4'b1111 raises out_fault for one cycle after the edge on which in_valid was high. It leaves every register unchanged and raises no out_done.
- R7: The legacy encoding never raises out_fault, whatever in_vvvv holds.
- R8: A register number is formed as {ext & in_long_mode, 3-bit field}, for the destination with in_ext_dst and for the source with in_ext_src. Registers 8 to 15 can be reached only in 64-bit mode.
- R9: An accepted operation updates the register file on the clock edge where in_valid is high. out_done is high for exactly the following cycle. While in_valid is low, nothing changes.
- R10: The reserved encoding 2'b11 raises out_fault and writes nothing.
- R11: Reset clears all 16 registers to zero and holds out_done and out_fault low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Decoded instruction present this cycle |
| in_enc | input | 2 | Encoding: 00 legacy, 01 VEX 128-bit, 10 VEX 256-bit, 11 reserved |
| in_dst | input | 3 | Destination register field |
| in_src | input | 3 | Source register field |
| in_ext_dst | input | 1 | Destination register extension bit |
| in_ext_src | input | 1 | Source register extension bit |
| in_long_mode | input | 1 | 64-bit mode; allows the extension bits to take effect |
| in_use_mem | input | 1 | 1 selects the load data as source, 0 the source register |
| in_vvvv | input | 4 | VEX.vvvv field; must be 4'b1111 for VEX encodings |
| in_mem_data | input | 256 | Load data |
| rd_idx | input | 4 | Read port register number |
| rd_data | output | 256 | Contents of register rd_idx |
| out_done | output | 1 | One-cycle pulse after a write |
| out_fault | output | 1 | One-cycle undefined-opcode pulse |

## Verification
The bench builds the unit with its default values: 64-bit elements, two 128-bit lanes and a 3-bit base register field. These values give sixteen 256-bit registers. With them the duplication in both lanes and the upper eight registers reached through the extension bits can all be exercised. Load data uses a different value in each 64-bit element, so the bench can tell a wrong element choice apart from a correct one. The bench reaches lanes above the second only through the elaboration checks and not through stimulus, because the default build has only two lanes.

// File: rtl/dupmov_pkg.sv
package dupmov_pkg;

   typedef enum logic [1:0] {
      ENC_LEGACY = 2'b00,
      ENC_VEX128 = 2'b01,
      ENC_VEX256 = 2'b10,
      ENC_RSVD   = 2'b11
   } enc_e;

   localparam logic [3:0] VVVV_UNUSED = 4'b1111;

endpackage

// File: rtl/dupmov_decode.sv
module dupmov_decode
   import dupmov_pkg::*;
#(
   parameter int BASE_IDXW = 3
) (
   input  logic                 in_valid,
   input  enc_e                 enc,
   input  logic [3:0]           vvvv,
   input  logic [BASE_IDXW-1:0] dst,
   input  logic [BASE_IDXW-1:0] src,
   input  logic                 ext_dst,
   input  logic                 ext_src,
   input  logic                 long_mode,
   input  logic                 use_mem,
   output logic                 fault_now,
   output logic                 wr_now,
   output logic [BASE_IDXW:0]   dst_idx,
   output logic [BASE_IDXW:0]   src_idx,
   output logic                 narrow_mem
);

   logic bad_enc;
   logic bad_vvvv;
   logic illegal;

   always_comb begin
      bad_enc    = (enc == ENC_RSVD);
      bad_vvvv   = ((enc == ENC_VEX128) || (enc == ENC_VEX256)) && (vvvv != VVVV_UNUSED);
      illegal    = bad_enc || bad_vvvv;
      fault_now  = in_valid && illegal;
      wr_now     = in_valid && !illegal;
      dst_idx    = {ext_dst & long_mode, dst};
      src_idx    = {ext_src & long_mode, src};
      narrow_mem = use_mem && (enc != ENC_VEX256);
   end

endmodule

// File: rtl/dupmov_shuffle.sv
module dupmov_shuffle
   import dupmov_pkg::*;
#(
   parameter int DW    = 64,
   parameter int LANES = 2
) (
   input  enc_e                    enc,
   input  logic [LANES*2*DW-1:0]   src_vec,
   output logic [LANES*2*DW-1:0]   wr_data,
   output logic [LANES-1:0]        lane_keep
);

   localparam int LW = 2 * DW;

   logic unused_src_parity;
   assign unused_src_parity = ^src_vec;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (g == 0) begin : g_base
         assign wr_data[LW-1:0] = {2{src_vec[DW-1:0]}};
         assign lane_keep[0]    = 1'b0;
      end else if (g == 1) begin : g_second
         assign wr_data[2*LW-1:LW] = (enc == ENC_VEX256) ? {2{src_vec[LW+DW-1:LW]}} : '0;
         assign lane_keep[1]       = (enc == ENC_LEGACY);
      end else begin : g_upper
         assign wr_data[g*LW +: LW] = '0;
         assign lane_keep[g]        = (enc == ENC_LEGACY);
      end
   end

endmodule

// File: rtl/dupmov_regfile.sv
module dupmov_regfile #(
   parameter int LW    = 128,
   parameter int LANES = 2,
   parameter int NREG  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(NREG)-1:0]  wa,
   input  logic [LANES*LW-1:0]      wd,
   input  logic [LANES-1:0]         lane_keep,
   input  logic [$clog2(NREG)-1:0]  ra_a,
   output logic [LANES*LW-1:0]      rd_a,
   input  logic [$clog2(NREG)-1:0]  ra_b,
   output logic [LANES*LW-1:0]      rd_b
);

   localparam int AW = $clog2(NREG);
   localparam int VW = LANES * LW;

   logic [VW-1:0] regs [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NREG; r++) begin
            regs[r] <= '0;
         end
      end else if (we) begin
         for (int r = 0; r < NREG; r++) begin
            for (int l = 0; l < LANES; l++) begin
               if ((wa == AW'(r)) && !lane_keep[l]) begin
                  regs[r][l*LW +: LW] <= wd[l*LW +: LW];
               end
            end
         end
      end
   end

   assign rd_a = regs[ra_a];
   assign rd_b = regs[ra_b];

endmodule

// File: rtl/dupmov_unit.sv
module dupmov_unit
   import dupmov_pkg::*;
#(
   parameter int DW        = 64,
   parameter int LANES     = 2,
   parameter int BASE_IDXW = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [1:0]              in_enc,
   input  logic [BASE_IDXW-1:0]    in_dst,
   input  logic [BASE_IDXW-1:0]    in_src,
   input  logic                    in_ext_dst,
   input  logic                    in_ext_src,
   input  logic                    in_long_mode,
   input  logic                    in_use_mem,
   input  logic [3:0]              in_vvvv,
   input  logic [LANES*2*DW-1:0]   in_mem_data,
   input  logic [BASE_IDXW:0]      rd_idx,
   output logic [LANES*2*DW-1:0]   rd_data,
   output logic                    out_done,
   output logic                    out_fault
);

   localparam int LW   = 2 * DW;
   localparam int VW   = LANES * LW;
   localparam int IDXW = BASE_IDXW + 1;
   localparam int NREG = 1 << IDXW;

   if (DW < 8) begin : g_bad_dw
      $error("dupmov_unit: DW must be at least 8");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("dupmov_unit: LANES must be at least 2 for the 256-bit form");
   end
   if (BASE_IDXW < 1) begin : g_bad_idx
      $error("dupmov_unit: BASE_IDXW must be at least 1");
   end

   enc_e            enc;
   logic            fault_now;
   logic            wr_now;
   logic [IDXW-1:0] dst_idx;
   logic [IDXW-1:0] src_idx;
   logic            narrow_mem;
   logic [VW-1:0]   rf_src;
   logic [VW-1:0]   src_vec;
   logic [VW-1:0]   wr_data;
   logic [LANES-1:0] lane_keep;

   assign enc = enc_e'(in_enc);

   dupmov_decode #(.BASE_IDXW(BASE_IDXW)) u_decode (
      .in_valid   (in_valid),
      .enc        (enc),
      .vvvv       (in_vvvv),
      .dst        (in_dst),
      .src        (in_src),
      .ext_dst    (in_ext_dst),
      .ext_src    (in_ext_src),
      .long_mode  (in_long_mode),
      .use_mem    (in_use_mem),
      .fault_now  (fault_now),
      .wr_now     (wr_now),
      .dst_idx    (dst_idx),
      .src_idx    (src_idx),
      .narrow_mem (narrow_mem)
   );

   always_comb begin
      if (narrow_mem) begin
         src_vec = VW'(in_mem_data[DW-1:0]);
      end else if (in_use_mem) begin
         src_vec = in_mem_data;
      end else begin
         src_vec = rf_src;
      end
   end

   dupmov_shuffle #(.DW(DW), .LANES(LANES)) u_shuffle (
      .enc       (enc),
      .src_vec   (src_vec),
      .wr_data   (wr_data),
      .lane_keep (lane_keep)
   );

   dupmov_regfile #(.LW(LW), .LANES(LANES), .NREG(NREG)) u_regfile (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (wr_now),
      .wa        (dst_idx),
      .wd        (wr_data),
      .lane_keep (lane_keep),
      .ra_a      (src_idx),
      .rd_a      (rf_src),
      .ra_b      (rd_idx),
      .rd_b      (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_done  <= 1'b0;
         out_fault <= 1'b0;
      end else begin
         out_done  <= wr_now;
         out_fault <= fault_now;
      end
   end

endmodule

// File: rtl/dupmov_sva.sv
module dupmov_sva
   import dupmov_pkg::*;
#(
   parameter int DW        = 64,
   parameter int LANES     = 2,
   parameter int BASE_IDXW = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic [1:0]            in_enc,
   input logic [3:0]            in_vvvv,
   input logic [BASE_IDXW-1:0]  in_dst,
   input logic                  in_ext_dst,
   input logic                  in_long_mode,
   input logic [BASE_IDXW:0]    rd_idx,
   input logic [LANES*2*DW-1:0] rd_data,
   input logic                  out_done,
   input logic                  out_fault
);

   localparam int VW = LANES * 2 * DW;

   logic [BASE_IDXW:0] eff_dst;
   logic               vex_bad;
   assign eff_dst = {in_ext_dst & in_long_mode, in_dst};
   assign vex_bad = in_valid && ((in_enc == ENC_VEX128) || (in_enc == ENC_VEX256))
                    && (in_vvvv != VVVV_UNUSED);

   AST_BAD_VVVV_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      vex_bad |=> out_fault); // R6

   AST_BAD_VVVV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      vex_bad |=> (rd_idx != $past(rd_idx)) || (rd_data == $past(rd_data))); // R6

   AST_DONE_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_done && out_fault)); // R6

   AST_LEGACY_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_enc == ENC_LEGACY) |=> !out_fault); // R7

   AST_RSVD_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_enc == ENC_RSVD) |=> (out_fault && !out_done)); // R10

   AST_DONE_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> $past(in_valid)); // R9

   AST_V128_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_enc == ENC_VEX128 && in_vvvv == VVVV_UNUSED && rd_idx == eff_dst)
      |=> (rd_idx != $past(rd_idx)) || (rd_data[VW-1:2*DW] == '0)); // R3

   AST_LOW_HALVES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_enc != ENC_RSVD && rd_idx == eff_dst)
      |=> !out_done || (rd_idx != $past(rd_idx))
          || (rd_data[DW-1:0] == rd_data[2*DW-1:DW])); // R1

endmodule

bind dupmov_unit dupmov_sva #(
   .DW(DW), .LANES(LANES), .BASE_IDXW(BASE_IDXW)
) u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_enc       (in_enc),
   .in_vvvv      (in_vvvv),
   .in_dst       (in_dst),
   .in_ext_dst   (in_ext_dst),
   .in_long_mode (in_long_mode),
   .rd_idx       (rd_idx),
   .rd_data      (rd_data),
   .out_done     (out_done),
   .out_fault    (out_fault)
);

// File: tb/dupmov_unit_tb.sv
`timescale 1ns/1ps
module dupmov_unit_tb;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic [1:0]   in_enc;
   logic [2:0]   in_dst;
   logic [2:0]   in_src;
   logic         in_ext_dst;
   logic         in_ext_src;
   logic         in_long_mode;
   logic         in_use_mem;
   logic [3:0]   in_vvvv;
   logic [255:0] in_mem_data;
   logic [3:0]   rd_idx;
   logic [255:0] rd_data;
   logic         out_done;
   logic         out_fault;

   logic [255:0] ref_rf [16];
   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;

   always #2.5 clk = ~clk;

   dupmov_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_enc(in_enc),
      .in_dst(in_dst), .in_src(in_src), .in_ext_dst(in_ext_dst),
      .in_ext_src(in_ext_src), .in_long_mode(in_long_mode),
      .in_use_mem(in_use_mem), .in_vvvv(in_vvvv), .in_mem_data(in_mem_data),
      .rd_idx(rd_idx), .rd_data(rd_data), .out_done(out_done), .out_fault(out_fault)
   );

   task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic sweep(input string req);
      for (int i = 0; i < 16; i++) begin
         rd_idx = 4'(i);
         #0.1;
         chk(rd_data === ref_rf[i], $sformatf("%s reg%0d", req, i), rd_data, ref_rf[i]);
      end
   endtask

   // Behavioural model of one operation; called at a falling edge.
   task automatic do_op(input string req, input logic [1:0] enc, input logic [2:0] d, input logic [2:0] s,
                        input bit xd, input bit xs, input bit lm, input bit mem,
                        input logic [3:0] vv, input logic [255:0] md);
      logic [3:0]   di;
      logic [3:0]   si;
      logic [255:0] srcv;
      logic [255:0] nv;
      bit           bad;
      di   = {xd & lm, d};
      si   = {xs & lm, s};
      bad  = (enc == 2'b11) || (enc != 2'b00 && vv != 4'hF);
      srcv = mem ? md : ref_rf[si];
      if (mem && enc != 2'b10) srcv = {192'b0, md[63:0]};
      nv = ref_rf[di];
      nv[63:0]   = srcv[63:0];
      nv[127:64] = srcv[63:0];
      if (enc == 2'b01) nv[255:128] = '0;
      else if (enc == 2'b10) begin
         nv[191:128] = srcv[191:128];
         nv[255:192] = srcv[191:128];
      end
      in_valid = 1'b1; in_enc = enc; in_dst = d; in_src = s;
      in_ext_dst = xd; in_ext_src = xs; in_long_mode = lm;
      in_use_mem = mem; in_vvvv = vv; in_mem_data = md; rd_idx = di;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (!bad) ref_rf[di] = nv;
      chk(out_done === !bad, {req, " done"}, 256'(out_done), 256'(!bad));
      chk(out_fault === bad, {req, " fault"}, 256'(out_fault), 256'(bad));
      chk(rd_data === ref_rf[di], {req, " data"}, rd_data, ref_rf[di]);
   endtask

   task automatic idle(input string req, input logic [3:0] ridx);
      in_valid = 1'b0; in_enc = 2'b10; in_vvvv = 4'hF; in_dst = 3'd4;
      in_use_mem = 1'b1; in_mem_data = {4{64'hDEAD_BEEF_0BAD_F00D}}; rd_idx = ridx;
      @(posedge clk);
      @(negedge clk);
      chk(out_done === 1'b0, {req, " idle done"}, 256'(out_done), 256'(0));
      chk(out_fault === 1'b0, {req, " idle fault"}, 256'(out_fault), 256'(0));
      chk(rd_data === ref_rf[ridx], {req, " idle data"}, rd_data, ref_rf[ridx]);
   endtask

   localparam logic [255:0] MA = {64'hA333_3333_3333_3A03, 64'hA222_2222_2222_2A02,
                                  64'hA111_1111_1111_1A01, 64'hA000_0000_0000_0A00};
   localparam logic [255:0] MB = {64'hB3B3_0000_1111_0003, 64'hB2B2_0000_1111_0002,
                                  64'hB1B1_0000_1111_0001, 64'hB0B0_0000_1111_0000};
   localparam logic [255:0] MC = {64'hC3C3_C3C3_C3C3_C3C3, 64'hC2C2_C2C2_C2C2_C2C2,
                                  64'hC1C1_C1C1_C1C1_C1C1, 64'h0C0C_0C0C_0C0C_0C0C};

   initial begin
      for (int i = 0; i < 16; i++) ref_rf[i] = '0;
      rst_n = 1'b0; in_valid = 1'b0; in_enc = 2'b00; in_dst = '0; in_src = '0;
      in_ext_dst = 1'b0; in_ext_src = 1'b0; in_long_mode = 1'b0; in_use_mem = 1'b0;
      in_vvvv = 4'hF; in_mem_data = '0; rd_idx = '0;
      repeat (3) @(negedge clk);
      chk(out_done === 1'b0 && out_fault === 1'b0, "R11 outputs in reset",
          256'({out_done, out_fault}), 256'(0));
      rst_n = 1'b1;
      @(negedge clk);
      sweep("R11 reset contents");

      do_op("R4 R5 vex256 mem r3",        2'b10, 3'd3, 3'd0, 0, 0, 1, 1, 4'hF, MA);
      do_op("R8 R4 vex256 mem r9",        2'b10, 3'd1, 3'd0, 1, 0, 1, 1, 4'hF, MB);
      do_op("R8 ext ignored outside lm",  2'b10, 3'd1, 3'd0, 1, 0, 0, 1, 4'hF, MC);
      do_op("R1 R2 legacy reg r3->r9",    2'b00, 3'd1, 3'd3, 1, 0, 1, 0, 4'hF, MC);
      do_op("R3 R8 vex128 reg r9->r5",    2'b01, 3'd5, 3'd1, 0, 1, 1, 0, 4'hF, '0);
      do_op("R5 R3 vex128 mem r3",        2'b01, 3'd3, 3'd0, 0, 0, 1, 1, 4'hF, MB);
      do_op("R5 R2 legacy mem r1",        2'b00, 3'd1, 3'd0, 0, 0, 0, 1, 4'hF, MA);
      do_op("R4 R1 vex256 reg r9->r10",   2'b10, 3'd2, 3'd1, 1, 1, 1, 0, 4'hF, MC);
      do_op("R4 vex256 mem r15",          2'b10, 3'd7, 3'd0, 1, 0, 1, 1, 4'hF, MC);
      do_op("R2 legacy reg r1->r15",      2'b00, 3'd7, 3'd1, 1, 0, 1, 0, 4'hF, '0);
      do_op("R6 vex128 bad vvvv",         2'b01, 3'd3, 3'd0, 0, 0, 1, 1, 4'h7, MC);
      do_op("R6 vex256 bad vvvv",         2'b10, 3'd1, 3'd2, 1, 1, 1, 0, 4'h0, '0);
      do_op("R6 vex256 vvvv 1110",        2'b10, 3'd7, 3'd0, 1, 0, 1, 1, 4'hE, MA);
      do_op("R7 legacy ignores vvvv",     2'b00, 3'd6, 3'd2, 0, 1, 1, 0, 4'h0, '0);
      do_op("R10 reserved encoding",      2'b11, 3'd6, 3'd0, 0, 0, 1, 1, 4'hF, MB);
      idle("R9 no valid", 4'd4);
      idle("R9 no valid r9", 4'd9);
      do_op("R1 R3 vex128 reg r10->r0",   2'b01, 3'd0, 3'd2, 0, 1, 1, 0, 4'hF, MA);
      sweep("R9 final contents");

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R9 watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule